// File: doc/BRIEF.md
# Parallel EPROM Byte Read Sequencer

This block sits on the host side of a bank of byte-wide parallel EPROMs and turns each read request into a correctly timed strobe sequence. A request carries a flat byte address. The upper bits choose one device of the bank and drive that device's active-low chip select. The lower bits go out on a shared address bus. One active-low output-enable line is common to all devices. A device drives the data bus only while its chip select and the shared output enable are both low, so every device that is not selected stays in standby.

The sequencer works in fixed clock-cycle windows. These windows are derived when the design is elaborated, from the clock period and from nanosecond access times for each speed grade. Each window is the time divided by the period, rounded up, with a floor of one cycle. The address and chip select go out first. Output enable follows once only the output-enable access window remains of the total access time. The data byte is registered at the end of that window, before the address can change, and both strobes are then released. The bus is left idle for the float window before another device can be selected. Results come back as a one-cycle done pulse with a held data byte.

Top module: `eprom_read_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, every `mem_ce_n` bit is 1, `mem_oe_n` is 1 and `rsp_done` is 0.
- R2: No more than one `mem_ce_n` bit is low at any time. During an access, the low bit is at index `req_addr[ADDR_W-1:DEV_ADDR_W]` of the accepted request.
- R3: `mem_oe_n` is low only in cycles where some `mem_ce_n` bit is low.
- R4: With W(t) = max(1, ceil(t / CLK_NS)), ACC = max(W(T_ACC_NS), W(T_CE_NS)) and OEW = W(T_OE_NS), the chip select is low for PRE cycles before `mem_oe_n` falls. PRE is ACC - OEW when that is positive and 1 otherwise. With the defaults this gives ACC = 12, OEW = 7 and PRE = 5.
- R5: `mem_oe_n` stays low for exactly OEW cycles. `rsp_done` then pulses high for one cycle. `rsp_data` equals the byte that was on `mem_data_in` in the last output-enable cycle.
- R6: `mem_addr` equals `req_addr[DEV_ADDR_W-1:0]` of the accepted request and does not change while a chip select is low.
- R7: After the strobes are released, every chip select stays high for at least FLT = W(T_FLOAT_NS) cycles (7 by default). `req_ready` is 0 from the cycle after acceptance until that float window has elapsed.
- R8: A request is accepted only in a cycle where both `req_valid` and `req_ready` are high. A request held while the sequencer is busy is served once, in order, using the address present at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer idle, request is taken on this edge |
| req_addr | input | ADDR_W | Flat byte address; the upper bits select the device |
| rsp_done | output | 1 | One-cycle pulse: `rsp_data` holds the byte just read |
| rsp_data | output | DATA_W | Last byte read |
| mem_addr | output | DEV_ADDR_W | Shared address bus to the devices |
| mem_ce_n | output | 2**(ADDR_W-DEV_ADDR_W) | Chip select for each device, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| mem_data_in | input | DATA_W | Data bus from the devices |

## Verification
The bound checker checks four properties on every cycle: at most one chip select is low, output enable is only low under a chip select, the address bus is stable while a device is selected, and the done pulse lasts a single cycle. Cycle counters in the checker also enforce the pre-enable, output-enable and float window lengths at each strobe edge. Only the bench scenarios can show that the right device is selected for each address, and that the registered byte is the one a device with real access delays presents. The bench scenarios also cover requests held through a busy period, which must be served once and in order, and an address that changes while a request waits, where the value present at acceptance must be used.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_FLOAT  = 2'd3
    } rd_state_e;

    // Nanoseconds to whole clock cycles, rounded up, never below one.
    function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                                 input int unsigned clk_ns);
        int unsigned c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/eprom_wait_timer.sv
module eprom_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/eprom_cs_decode.sv
module eprom_cs_decode #(
    parameter int SEL_W = 2,
    localparam int NUM_DEV = 1 << SEL_W
) (
    input  logic             enable,
    input  logic [SEL_W-1:0] sel,
    output logic [NUM_DEV-1:0] ce_n
);
    for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
        assign ce_n[i] = ~(enable && (sel == SEL_W'(i)));
    end
endmodule

// File: rtl/eprom_read_ctrl.sv
module eprom_read_ctrl
    import eprom_rd_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int DEV_ADDR_W = 16,
    parameter int DATA_W     = 8,
    parameter int CLK_NS     = 4,
    parameter int T_ACC_NS   = 45,
    parameter int T_CE_NS    = 45,
    parameter int T_OE_NS    = 25,
    parameter int T_FLOAT_NS = 25,
    localparam int SEL_W     = ADDR_W - DEV_ADDR_W,
    localparam int NUM_DEV   = 1 << SEL_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ADDR_W-1:0]     req_addr,
    output logic                  rsp_done,
    output logic [DATA_W-1:0]     rsp_data,
    output logic [DEV_ADDR_W-1:0] mem_addr,
    output logic [NUM_DEV-1:0]    mem_ce_n,
    output logic                  mem_oe_n,
    input  logic [DATA_W-1:0]     mem_data_in
);
    localparam int ACC_CYC = int'(max_u(ns_to_cycles(T_ACC_NS, CLK_NS),
                                        ns_to_cycles(T_CE_NS, CLK_NS)));
    localparam int OE_CYC  = int'(ns_to_cycles(T_OE_NS, CLK_NS));
    localparam int FLT_CYC = int'(ns_to_cycles(T_FLOAT_NS, CLK_NS));
    localparam int PRE_CYC = (ACC_CYC > OE_CYC) ? (ACC_CYC - OE_CYC) : 1;
    localparam int MAX_CYC = int'(max_u(max_u(PRE_CYC, OE_CYC), FLT_CYC));
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    typedef struct packed {
        rd_state_e         st;
        logic [ADDR_W-1:0] addr;
        logic              sel_en;
        logic              oe;
        logic              done;
        logic [DATA_W-1:0] data;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;

    eprom_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    eprom_cs_decode #(.SEL_W(SEL_W)) u_decode (
        .enable (ctl_q.sel_en),
        .sel    (ctl_q.addr[ADDR_W-1:DEV_ADDR_W]),
        .ce_n   (mem_ce_n)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.addr   = req_addr;
                    ctl_d.sel_en = 1'b1;
                    ctl_d.st     = ST_SETUP;
                    tmr_load     = 1'b1;
                    tmr_val      = CNT_W'(PRE_CYC - 1);
                end
            end
            ST_SETUP: begin
                if (tmr_expired) begin
                    ctl_d.oe = 1'b1;
                    ctl_d.st = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(OE_CYC - 1);
                end
            end
            ST_STROBE: begin
                if (tmr_expired) begin
                    ctl_d.data   = mem_data_in;
                    ctl_d.done   = 1'b1;
                    ctl_d.sel_en = 1'b0;
                    ctl_d.oe     = 1'b0;
                    ctl_d.st     = ST_FLOAT;
                    tmr_load     = 1'b1;
                    tmr_val      = CNT_W'(FLT_CYC - 1);
                end
            end
            ST_FLOAT: begin
                if (tmr_expired) ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, addr: '0, sel_en: 1'b0, oe: 1'b0,
                       done: 1'b0, data: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready = (ctl_q.st == ST_IDLE);
    assign mem_addr  = ctl_q.addr[DEV_ADDR_W-1:0];
    assign mem_oe_n  = ~ctl_q.oe;
    assign rsp_done  = ctl_q.done;
    assign rsp_data  = ctl_q.data;
endmodule

// File: rtl/eprom_read_ctrl_chk.sv
module eprom_read_ctrl_chk #(
    parameter int NUM_DEV    = 4,
    parameter int DEV_ADDR_W = 16,
    parameter int PRE_CYC    = 5,
    parameter int OE_CYC     = 7,
    parameter int FLT_CYC    = 7
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_ready,
    input logic                  rsp_done,
    input logic [DEV_ADDR_W-1:0] mem_addr,
    input logic [NUM_DEV-1:0]    mem_ce_n,
    input logic                  mem_oe_n
);
    logic        ce_any;
    logic [15:0] ce_run_q, oe_run_q, gap_q;

    assign ce_any = (mem_ce_n != '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_run_q <= '0;
            oe_run_q <= '0;
            gap_q    <= 16'(FLT_CYC);
        end else begin
            ce_run_q <= ce_any ? ((ce_run_q == '1) ? ce_run_q : ce_run_q + 1'b1) : '0;
            oe_run_q <= !mem_oe_n ? ((oe_run_q == '1) ? oe_run_q : oe_run_q + 1'b1) : '0;
            gap_q    <= ce_any ? '0 : ((gap_q == '1) ? gap_q : gap_q + 1'b1);
        end
    end

    assert_one_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~mem_ce_n) <= 1);

    assert_oe_under_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> ce_any);

    assert_pre_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> (ce_run_q == 16'(PRE_CYC)));

    assert_oe_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (oe_run_q == 16'(OE_CYC)));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_any && $past(ce_any)) |-> $stable(mem_addr));

    assert_float_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ce_any) |-> (gap_q >= 16'(FLT_CYC)));

    assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ce_any |-> !req_ready);
endmodule

bind eprom_read_ctrl eprom_read_ctrl_chk #(
    .NUM_DEV    (NUM_DEV),
    .DEV_ADDR_W (DEV_ADDR_W),
    .PRE_CYC    (PRE_CYC),
    .OE_CYC     (OE_CYC),
    .FLT_CYC    (FLT_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n)
);

// File: tb/sim_eprom_read_ctrl.sv
module sim_eprom_read_ctrl;
    localparam int ADDR_W = 18;
    localparam int DEV_W  = 16;
    localparam int DATA_W = 8;
    localparam int NDEV   = 1 << (ADDR_W - DEV_W);
    // Expected windows at 4 ns: ceil(45/4)=12, ceil(25/4)=7, float ceil(25/4)=7
    localparam int ACC = 12;
    localparam int OEW = 7;
    localparam int PRE = ACC - OEW;
    localparam int FLT = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              rsp_done;
    logic [DATA_W-1:0] rsp_data;
    logic [DEV_W-1:0]  mem_addr;
    logic [NDEV-1:0]   mem_ce_n;
    logic              mem_oe_n;
    logic [DATA_W-1:0] mem_data_in;

    always #2 clk = ~clk;

    eprom_read_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_done(rsp_done), .rsp_data(rsp_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_data_in(mem_data_in)
    );

    int checks = 0;
    int fails  = 0;
    int issued = 0;
    int served = 0;
    logic [ADDR_W-1:0] exp_q[$];

    function automatic logic [7:0] rom_byte(input int dev, input logic [DEV_W-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'(dev * 8'h35) ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Device model: drives the stored byte only after the access delays have elapsed.
    int mdl_ce_cnt = 0;
    int mdl_oe_cnt = 0;
    int sel_dev;
    always @(posedge clk) begin
        mdl_ce_cnt <= (mem_ce_n != '1) ? mdl_ce_cnt + 1 : 0;
        mdl_oe_cnt <= !mem_oe_n ? mdl_oe_cnt + 1 : 0;
    end
    always_comb begin
        sel_dev = 0;
        for (int i = NDEV - 1; i >= 0; i--) if (!mem_ce_n[i]) sel_dev = i;
        if ((mem_ce_n != '1) && !mem_oe_n && mdl_oe_cnt >= OEW - 1 && mdl_ce_cnt >= ACC - 1)
            mem_data_in = rom_byte(sel_dev, mem_addr);
        else
            mem_data_in = ~rom_byte(sel_dev, mem_addr);
    end

    // Monitor / scoreboard
    bit prev_ce = 0, prev_oe = 0, prev_done = 0;
    int ce_run = 0, oe_run = 0, gap = 1000;
    always @(negedge clk) begin
        if (rst_n) begin
            automatic bit ce_any = (mem_ce_n != '1);
            automatic bit oe_low = !mem_oe_n;
            if (oe_low) chk(ce_any, "R3", "oe without ce", int'(mem_ce_n), 0);
            if (ce_any && !prev_ce) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R8", "access without request", 1, 0);
                end else begin
                    automatic logic [ADDR_W-1:0] e = exp_q[0];
                    automatic int dev = int'(e[ADDR_W-1:DEV_W]);
                    chk(gap >= FLT, "R7", "float gap", gap, FLT);
                    chk(mem_ce_n == ~(NDEV'(1) << dev), "R2", "chip select", int'(mem_ce_n),
                        int'(~(NDEV'(1) << dev)));
                    chk(mem_addr == e[DEV_W-1:0], "R6", "address", int'(mem_addr),
                        int'(e[DEV_W-1:0]));
                    chk(!req_ready, "R7", "ready while busy", int'(req_ready), 0);
                end
            end
            if (oe_low && !prev_oe) begin
                chk(ce_run == PRE, "R4", "ce before oe", ce_run, PRE);
                if (exp_q.size() != 0)
                    chk(mem_addr == exp_q[0][DEV_W-1:0], "R6", "address held",
                        int'(mem_addr), int'(exp_q[0][DEV_W-1:0]));
            end
            if (!oe_low && prev_oe) chk(oe_run == OEW, "R5", "oe width", oe_run, OEW);
            if (rsp_done) begin
                chk(!prev_done, "R5", "done width", 2, 1);
                if (exp_q.size() != 0) begin
                    automatic logic [ADDR_W-1:0] e = exp_q.pop_front();
                    automatic logic [7:0] x = rom_byte(int'(e[ADDR_W-1:DEV_W]), e[DEV_W-1:0]);
                    chk(rsp_data == x, "R5", "read data", int'(rsp_data), int'(x));
                end
                served++;
            end
            ce_run    = ce_any ? ce_run + 1 : 0;
            oe_run    = oe_low ? oe_run + 1 : 0;
            gap       = ce_any ? 0 : gap + 1;
            prev_ce   = ce_any;
            prev_oe   = oe_low;
            prev_done = rsp_done;
        end
    end

    task automatic wait_accept();
        forever begin
            if (req_ready) begin
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    task automatic issue(input logic [ADDR_W-1:0] a);
        req_addr  = a;
        req_valid = 1'b1;
        exp_q.push_back(a);
        issued++;
        wait_accept();
    endtask

    // Address changes while the request waits: the value at acceptance counts (R8)
    task automatic issue_swap(input logic [ADDR_W-1:0] a1, input logic [ADDR_W-1:0] a2);
        req_addr  = a1;
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        req_addr = a2;
        exp_q.push_back(a2);
        issued++;
        wait_accept();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready in reset", int'(req_ready), 1);
        chk(mem_ce_n == '1, "R1", "ce in reset", int'(mem_ce_n), int'({NDEV{1'b1}}));
        chk(mem_oe_n == 1'b1, "R1", "oe in reset", int'(mem_oe_n), 1);
        chk(rsp_done == 1'b0, "R1", "done in reset", int'(rsp_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && mem_ce_n == '1, "R1", "idle after reset",
            int'(req_ready), 1);

        issue(18'h00000);
        repeat (30) @(negedge clk);
        issue(18'h3FFFF);
        issue(18'h1FFFF);          // held while busy, R8
        issue(18'h2A5C3);
        issue(18'h10001);
        issue_swap(18'h0BEEF, 18'h3C0DE);
        repeat (5) @(negedge clk);
        for (int d = 0; d < NDEV; d++) issue({2'(d), 16'h8000 + 16'(d)});
        repeat (40) @(negedge clk);
        chk(exp_q.size() == 0, "R8", "pending after drain", exp_q.size(), 0);
        chk(served == issued, "R8", "served count", served, issued);
        chk(mem_ce_n == '1 && mem_oe_n && req_ready, "R7", "idle at end",
            int'(mem_ce_n), int'({NDEV{1'b1}}));
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule